// File: doc/BRIEF.md
# Pipelined Single-Beat Bus Master

This block turns a stream of single-word read and write commands into transfers on an AHB-Lite style bus. Each command arrives on a valid/ready request port. The master holds two slots. The first holds the transfer whose address phase is on the bus. The second holds the transfer whose data phase is in progress. At every rising edge where the slave reports ready, the data-phase transfer retires and the address-phase transfer moves up behind it. Because of this, the next address is on the bus in the same cycle as the previous transfer's data.

Every retired transfer produces a result on a response port one cycle after it completes. The result carries the write flag, the aligned address, the captured read data and a one-bit status. Only word-sized, single-beat transfers are issued. Addresses are forced onto word boundaries. When no command is pending, the master drives an idle transfer and does not stall.

Top module: `ahbl_pipe_master`

## Requirements
- R1: While `rstN` is low, `htrans` is IDLE (2'b00), `cmdReady` is low and `rspValid` is low, even if `cmdValid` is high.
- R2: When a command is accepted (`cmdValid` and `cmdReady` high at a rising edge), the following cycle shows `htrans` = NONSEQ (2'b10), `haddr` = `cmdAddr` with bits [1:0] cleared, `hwrite` = `cmdWrite`, `hburst` = 3'b000 (single) and `hsize` = 3'b010 (word).
- R3: Whenever the address slot is empty, `htrans` is IDLE (2'b00) and `hwrite` is 0.
- R4: While `hready` is low, an occupied address phase keeps `haddr`, `hwrite` and `htrans` unchanged.
- R5: The write data of a transfer appears on `hwdata` in the cycle after its address phase completes. It stays there until the rising edge at which `hready` is high again.
- R6: `cmdReady` is high exactly when the address slot is empty or `hready` is high. Commands offered every cycle with `hready` high therefore produce NONSEQ transfers in consecutive cycles with no idle cycle between them.
- R7: A read whose data phase completes (an edge with `hready` high) gives, in the next cycle only, `rspValid` = 1, `rspWrite` = 0, `rspAddr` = its aligned address, `rspRdata` = `hrdata` sampled at that edge and `rspErr` = `hresp` sampled at that edge (0 = OKAY, 1 = ERROR).
- R8: A completed write gives a one-cycle response with `rspWrite` = 1, `rspRdata` = 0 and `rspErr` = `hresp` sampled at the completing edge.
- R9: Every accepted command produces exactly one response, and responses come out in the order the commands were accepted.
- R10: When `hready` is low and the address slot is empty, `cmdReady` is still high, so a command is taken in during a wait state.
- R11: `haddr[1:0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is offered |
| cmdReady | output | 1 | Command is taken at this edge |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W | Byte address of the command |
| cmdWdata | input | DATA_W | Write data of the command |
| haddr | output | ADDR_W | Bus address, word aligned |
| htrans | output | 2 | Transfer type: 00 idle, 10 non-sequential |
| hwrite | output | 1 | Bus write flag |
| hsize | output | 3 | Transfer size, fixed to word |
| hburst | output | 3 | Burst type, fixed to single |
| hwdata | output | DATA_W | Bus write data, data phase |
| hrdata | input | DATA_W | Bus read data |
| hready | input | 1 | Slave ready; low inserts a wait state |
| hresp | input | 1 | Slave status: 0 OKAY, 1 ERROR |
| rspValid | output | 1 | One-cycle strobe for a completed transfer |
| rspWrite | output | 1 | Write flag of the completed transfer |
| rspAddr | output | ADDR_W | Aligned address of the completed transfer |
| rspRdata | output | DATA_W | Captured read data, 0 for writes |
| rspErr | output | 1 | Captured status of the completed transfer |

## Verification
The delicate cycle is the one where a transfer retires from the data slot, the address-phase transfer moves into the data slot, and a new command is loaded into the freed address slot, all at one edge. The bench provokes this by offering commands every cycle with `hready` held high, and again with a `hready` pattern that drops every third cycle. A bus slave model in the bench stores writes and serves reads from the bus itself. Each response is then compared in acceptance order against a reference memory that is updated when each command is issued, so a lost, doubled or reordered hand-over shows up as a wrong address or wrong data.

// File: rtl/ahbl_pipe_pkg.sv
`timescale 1ns/1ps
package ahbl_pipe_pkg;

  // Transfer type encoding on the bus
  typedef enum logic [1:0] {
    TRANS_IDLE   = 2'b00,
    TRANS_BUSY   = 2'b01,
    TRANS_NONSEQ = 2'b10,
    TRANS_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;

  // Control to datapath strobes
  typedef struct packed {
    logic loadAddr;   // capture an accepted command into the address slot
    logic shiftData;  // address slot moves into the data slot
    logic complete;   // data slot transfer retires at this edge
  } pipe_strobe_t;

endpackage

// File: rtl/ahbl_pipe_ctrl.sv
`timescale 1ns/1ps
module ahbl_pipe_ctrl
  import ahbl_pipe_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         hready,
  output logic         cmdReady,
  output logic         addrBusy,
  output logic         rspValid,
  output pipe_strobe_t strobe
);

  logic addrBusyQ;
  logic dataBusyQ;
  logic rspValidQ;
  logic accept;

  // Address slot frees on this edge when hready is high
  assign cmdReady = rstN & (~addrBusyQ | hready);
  assign accept   = cmdValid & cmdReady;

  always_comb begin
    strobe           = '0;
    strobe.loadAddr  = accept;
    strobe.shiftData = hready;
    strobe.complete  = hready & dataBusyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrBusyQ <= 1'b0;
      dataBusyQ <= 1'b0;
      rspValidQ <= 1'b0;
    end else begin
      if (accept)      addrBusyQ <= 1'b1;
      else if (hready) addrBusyQ <= 1'b0;

      if (hready) dataBusyQ <= addrBusyQ;

      rspValidQ <= hready & dataBusyQ;
    end
  end

  assign addrBusy = addrBusyQ;
  assign rspValid = rspValidQ;

  // R4: an address phase in a wait state stays occupied
  p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addrBusyQ && !hready) |=> addrBusyQ);

  // R2: an accepted command occupies the address slot next cycle
  p_accept_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> addrBusyQ);

  // R9: a response only follows a data phase that retired
  p_rsp_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValidQ |-> $past(dataBusyQ && hready));

  // R9: an address phase that completes always enters the data slot
  p_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addrBusyQ && hready) |=> dataBusyQ);

  // R6: no command taken while the address slot is stuck
  p_no_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addrBusyQ && !hready) |-> !strobe.loadAddr);

endmodule

// File: rtl/ahbl_pipe_dpath.sv
`timescale 1ns/1ps
module ahbl_pipe_dpath
  import ahbl_pipe_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipe_strobe_t      strobe,
  input  logic              addrBusy,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hresp,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  output logic              rspWrite,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);

  localparam int unsigned          LOW_BITS   = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0]    ALIGN_MASK = ADDR_W'((1 << LOW_BITS) - 1);
  localparam logic [2:0]           SIZE_CODE  = 3'(LOW_BITS);

  logic [ADDR_W-1:0] alignedAddr;

  // Address slot
  logic              aWriteQ;
  logic [ADDR_W-1:0] aAddrQ;
  logic [DATA_W-1:0] aWdataQ;

  // Data slot
  logic              dWriteQ;
  logic [ADDR_W-1:0] dAddrQ;
  logic [DATA_W-1:0] dWdataQ;

  // Response registers
  logic              rWriteQ;
  logic [ADDR_W-1:0] rAddrQ;
  logic [DATA_W-1:0] rDataQ;
  logic              rErrQ;

  assign alignedAddr = cmdAddr & ~ALIGN_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aWriteQ <= 1'b0;
      aAddrQ  <= '0;
      aWdataQ <= '0;
    end else if (strobe.loadAddr) begin
      aWriteQ <= cmdWrite;
      aAddrQ  <= alignedAddr;
      aWdataQ <= cmdWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dWriteQ <= 1'b0;
      dAddrQ  <= '0;
      dWdataQ <= '0;
    end else if (strobe.shiftData) begin
      dWriteQ <= aWriteQ;
      dAddrQ  <= aAddrQ;
      dWdataQ <= aWdataQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rWriteQ <= 1'b0;
      rAddrQ  <= '0;
      rDataQ  <= '0;
      rErrQ   <= 1'b0;
    end else if (strobe.complete) begin
      rWriteQ <= dWriteQ;
      rAddrQ  <= dAddrQ;
      rDataQ  <= dWriteQ ? '0 : hrdata;
      rErrQ   <= hresp;
    end
  end

  // Bus drive
  assign haddr  = aAddrQ;
  assign htrans = addrBusy ? TRANS_NONSEQ : TRANS_IDLE;
  assign hwrite = addrBusy & aWriteQ;
  assign hsize  = SIZE_CODE;
  assign hburst = BURST_SINGLE;
  assign hwdata = dWdataQ;

  assign rspWrite = rWriteQ;
  assign rspAddr  = rAddrQ;
  assign rspRdata = rDataQ;
  assign rspErr   = rErrQ;

  // R11: bus address never leaves a word boundary
  p_addr_aligned_r11: assert property (@(posedge clk) disable iff (!rstN)
    (haddr & ALIGN_MASK) == '0);

  // R4: address phase outputs frozen during a wait state
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addrBusy && !strobe.shiftData) |=> ($stable(haddr) && $stable(hwrite)));

  // R5: write data frozen until the data phase completes
  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftData |=> $stable(hwdata));

  // R3: an idle transfer is never flagged as a write
  p_idle_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (htrans == TRANS_IDLE) |-> !hwrite);

  // R8: write responses carry no read data
  p_wr_rsp_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.complete && dWriteQ) |=> (rspRdata == '0));

endmodule

// File: rtl/ahbl_pipe_master.sv
`timescale 1ns/1ps
module ahbl_pipe_master
  import ahbl_pipe_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  input  logic              hresp,
  output logic              rspValid,
  output logic              rspWrite,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);

  pipe_strobe_t strobe;
  logic         addrBusy;

  ahbl_pipe_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .hready   (hready),
    .cmdReady (cmdReady),
    .addrBusy (addrBusy),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  ahbl_pipe_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addrBusy (addrBusy),
    .cmdWrite (cmdWrite),
    .cmdAddr  (cmdAddr),
    .cmdWdata (cmdWdata),
    .hrdata   (hrdata),
    .hresp    (hresp),
    .haddr    (haddr),
    .htrans   (htrans),
    .hwrite   (hwrite),
    .hsize    (hsize),
    .hburst   (hburst),
    .hwdata   (hwdata),
    .rspWrite (rspWrite),
    .rspAddr  (rspAddr),
    .rspRdata (rspRdata),
    .rspErr   (rspErr)
  );

endmodule

// File: tb/ahbl_pipe_master_test.sv
`timescale 1ns/1ps
module ahbl_pipe_master_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic        cmdWrite = 1'b0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdWdata = '0;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic [31:0] hwdata;
  logic [31:0] hrdata;
  logic        hready;
  logic        hresp;
  logic        rspValid;
  logic        rspWrite;
  logic [31:0] rspAddr;
  logic [31:0] rspRdata;
  logic        rspErr;

  always #10 clk = ~clk;

  ahbl_pipe_master uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
    .hresp(hresp), .rspValid(rspValid), .rspWrite(rspWrite),
    .rspAddr(rspAddr), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  // ---------------- counters and check helper ----------------
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // ---------------- hready control ----------------
  int hrMode = 0;          // 0 high, 1 low, 2 pattern
  int patCnt = 0;
  always @(negedge clk) patCnt <= patCnt + 1;
  assign hready = (hrMode == 0) ? 1'b1 : (hrMode == 1) ? 1'b0 : ((patCnt % 3) != 2);

  // ---------------- bus slave model ----------------
  logic [31:0] mem [16];
  logic        sDV, sDW;
  logic [31:0] sDA;

  function automatic logic [31:0] initVal(input int i);
    return 32'h1000_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= initVal(i);
      sDV <= 1'b0; sDW <= 1'b0; sDA <= '0;
    end else if (hready) begin
      if (sDV && sDW && !sDA[7]) mem[sDA[5:2]] <= hwdata;
      sDV <= (htrans == 2'b10);
      sDA <= haddr;
      sDW <= hwrite;
    end
  end

  assign hrdata = (sDV && !sDW && !sDA[7]) ? mem[sDA[5:2]] : 32'h0;
  assign hresp  = sDV && sDA[7];

  // ---------------- expected response queue ----------------
  logic [31:0] refMem [16];
  logic        expWr   [256];
  logic [31:0] expAddr [256];
  logic [31:0] expData [256];
  logic        expErr  [256];
  int nIss = 0;
  int nRsp = 0;

  initial for (int i = 0; i < 16; i++) refMem[i] = initVal(i);

  task automatic pushExp(input logic wr, input logic [31:0] addr,
                         input logic [31:0] wdata, input logic err);
    logic [31:0] al;
    al = addr & ~32'h3;
    expWr[nIss]   = wr;
    expAddr[nIss] = al;
    expErr[nIss]  = err;
    expData[nIss] = (wr || err) ? 32'h0 : refMem[al[5:2]];
    if (wr && !err) refMem[al[5:2]] = wdata;
    nIss++;
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge
  task automatic sendCmd(input logic wr, input logic [31:0] addr,
                         input logic [31:0] wdata, input logic err);
    logic r;
    cmdValid = 1'b1; cmdWrite = wr; cmdAddr = addr; cmdWdata = wdata;
    forever begin
      #1 r = cmdReady;
      @(posedge clk);
      @(negedge clk);
      if (r) break;
    end
    cmdValid = 1'b0;
    pushExp(wr, addr, wdata, err);
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (nRsp == nIss) break;
      @(negedge clk);
    end
    chk("R9 drain", 32'(nRsp), 32'(nIss));
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (htrans == 2'b00) chk("R3 idle hwrite", 32'(hwrite), 32'h0);
      if (htrans == 2'b10) chk("R11 haddr low bits", 32'(haddr[1:0]), 32'h0);
      if (rspValid) begin
        if (nRsp >= nIss) begin
          chk("R9 extra response", 32'(nRsp), 32'(nIss - 1));
        end else begin
          chk("R9 order write flag", 32'(rspWrite), 32'(expWr[nRsp]));
          chk("R9 order address", rspAddr, expAddr[nRsp]);
          if (expWr[nRsp]) begin
            chk("R8 write rdata", rspRdata, 32'h0);
            chk("R8 write status", 32'(rspErr), 32'(expErr[nRsp]));
          end else begin
            chk("R7 read data", rspRdata, expData[nRsp]);
            chk("R7 read status", 32'(rspErr), 32'(expErr[nRsp]));
          end
          nRsp++;
        end
      end
    end
  end

  // ---------------- stimulus table ----------------
  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic        err;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 32'h0000_0004, 32'hA5A5_0001, 1'b0},
    '{1'b1, 32'h0000_0008, 32'h1234_5678, 1'b0},
    '{1'b0, 32'h0000_0004, 32'h0,         1'b0},
    '{1'b0, 32'h0000_0009, 32'h0,         1'b0},
    '{1'b1, 32'h0000_008C, 32'hDEAD_0000, 1'b1},
    '{1'b0, 32'h0000_000C, 32'h0,         1'b0},
    '{1'b1, 32'h0000_003C, 32'h0BAD_F00D, 1'b0},
    '{1'b0, 32'h0000_003C, 32'h0,         1'b0},
    '{1'b0, 32'h0000_0080, 32'h0,         1'b1},
    '{1'b1, 32'h0000_0010, 32'h55AA_55AA, 1'b0},
    '{1'b1, 32'h0000_0012, 32'h66BB_66BB, 1'b0},
    '{1'b0, 32'h0000_0013, 32'h0,         1'b0}
  };

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

  // ---------------- main sequence ----------------
  logic [31:0] savedAddr;
  initial begin
    // R1: reset state with a command offered
    cmdValid = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 htrans in reset", 32'(htrans), 32'h0);
    chk("R1 cmdReady in reset", 32'(cmdReady), 32'h0);
    chk("R1 rspValid in reset", 32'(rspValid), 32'h0);
    cmdValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R3 idle after reset", 32'(htrans), 32'h0);

    // Table walk: pass 0 hready high, pass 1 with wait-state pattern
    for (int pass = 0; pass < 2; pass++) begin
      hrMode = (pass == 0) ? 0 : 2;
      for (int v = 0; v < 12; v++)
        sendCmd(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].err);
      drain();
    end
    hrMode = 0;
    @(negedge clk);

    // R2 / R5: address phase fields, then write data in data phase
    sendCmd(1'b1, 32'h0000_0023, 32'hCAFE_0001, 1'b0);
    chk("R2 htrans nonseq", 32'(htrans), 32'h2);
    chk("R2 haddr aligned", haddr, 32'h0000_0020);
    chk("R2 hwrite", 32'(hwrite), 32'h1);
    chk("R2 hburst single", 32'(hburst), 32'h0);
    chk("R2 hsize word", 32'(hsize), 32'h2);
    @(negedge clk);
    chk("R3 idle after single", 32'(htrans), 32'h0);
    chk("R5 hwdata in data phase", hwdata, 32'hCAFE_0001);
    drain();

    // R10 / R6 / R4: wait state with empty then full address slot
    hrMode = 1;
    #1 chk("R10 ready with empty slot in wait", 32'(cmdReady), 32'h1);
    sendCmd(1'b0, 32'h0000_0020, 32'h0, 1'b0);
    #1 chk("R6 ready low when slot stuck", 32'(cmdReady), 32'h0);
    savedAddr = haddr;
    repeat (3) @(negedge clk);
    chk("R4 haddr held", haddr, savedAddr);
    chk("R4 htrans held", 32'(htrans), 32'h2);
    chk("R4 hwrite held", 32'(hwrite), 32'h0);
    hrMode = 0;
    drain();

    // R5: write data held through a data-phase wait
    sendCmd(1'b1, 32'h0000_0024, 32'h7777_0000, 1'b0);
    @(negedge clk);
    hrMode = 1;
    repeat (3) @(negedge clk);
    chk("R5 hwdata held in wait", hwdata, 32'h7777_0000);
    hrMode = 0;
    drain();

    // R6: back-to-back, no idle cycle
    sendCmd(1'b1, 32'h0000_0030, 32'h1111_2222, 1'b0);
    #1 chk("R6 ready with busy slot and hready", 32'(cmdReady), 32'h1);
    sendCmd(1'b0, 32'h0000_0024, 32'h0, 1'b0);
    chk("R6 consecutive nonseq", 32'(htrans), 32'h2);
    chk("R6 second address", haddr, 32'h0000_0024);
    drain();

    repeat (3) @(negedge clk);
    chk("R9 response count", 32'(nRsp), 32'(nIss));
    finishRun();
  end

endmodule